// File: doc/BRIEF.md
# Serial Static RAM Slave with Transfer Pause

This block is the device end of a byte-wide static RAM reached over a four-wire SPI link plus an active-low pause input. A controller lowers chip select, shifts in an 8-bit command and, for array access, a 16-bit address. It then streams bytes into or out of an internal register-file array, or reads or writes an 8-bit status byte. All fields travel most significant bit first. The serial output comes with a separate drive-enable, so the pad ring can build the three-state driver.

The pins are oversampled by a fast system clock. A synchronizer brings chip select, serial clock, serial data and pause into the clock domain. A pause controller decides which serial clock edges count. A sequencer state machine walks the states ST_IDLE, ST_OPCODE, ST_ADDR, ST_WR_DATA, ST_RD_DATA, ST_WR_STAT, ST_RD_STAT and ST_DISCARD.

The transitions are:
- ST_IDLE goes to ST_OPCODE once select is seen low.
- ST_OPCODE goes to ST_ADDR for a read or write command, to ST_RD_STAT or ST_WR_STAT for a status command, and to ST_DISCARD for any other code.
- ST_ADDR goes to ST_RD_DATA or ST_WR_DATA after its sixteenth bit.
- ST_WR_STAT goes to ST_DISCARD after one byte.
- Every state returns to ST_IDLE when select goes high.

The array depth is set by `ARRAY_AW`. It defaults to 11 (2048 bytes) to keep elaboration light. The full 8192-byte part uses `ARRAY_AW = 13`.

Top module: `serial_sram_slave`

## Requirements
- R1: Command codes are 8 bits, sent MSB first: 0x03 reads the array, 0x02 writes the array, 0x05 reads the status byte and 0x01 writes it. Addresses and data also move MSB first.
- R2: `si` is sampled on rising `sck` edges. `so` changes only after falling `sck` edges. The first rising edge after `cs_n` falls carries command bit 7.
- R3: While `cs_n` is high, the block is idle and `so_oe` is 0, including after reset. Raising `cs_n` ends the sequence at once and drops `so_oe`.
- R4: The 16 address bits follow the command, MSB first. Only the low `ARRAY_AW` bits select the byte; the upper bits are ignored.
- R5: In read and write, the address steps up by one after each byte and wraps from 2**ARRAY_AW-1 to 0. Streaming continues until `cs_n` rises.
- R6: A byte is written to the array when its eighth bit is sampled. A byte cut short by `cs_n` rising leaves the array unchanged.
- R7: After reset the status byte is 0x00. The status write command stores only the first data byte and ignores later ones. The status read command returns the byte again and again, every 8 clocks.
- R8: Lowering `hold_n` drops `so_oe` at once, whatever the `sck` level. If `sck` is low at that time, the pause begins immediately.
- R9: If `hold_n` falls while `sck` is high, the pause begins only after the next falling `sck` edge, and that falling edge still takes effect.
- R10: While paused, `sck` and `si` are ignored. The pause ends when `hold_n` is high while `sck` is low, and the transfer resumes at the exact bit where it stopped.
- R11: An unknown command code is ignored. `so_oe` stays 0 until `cs_n` rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock from the controller |
| si | input | 1 | Serial data into the block |
| hold_n | input | 1 | Active-low pause request |
| so | output | 1 | Serial data out of the block |
| so_oe | output | 1 | Drive enable for `so`; 0 means high impedance |

## Verification
A wrong bit counter or sequencer state shows up at the ports within one byte time: read-back data comes out shifted or from the wrong address, or `so_oe` rises during a command that should stay silent. A fault in the pause controller appears as a byte whose bits are shifted by one across the pause. It can also appear as `so_oe` still high within a nanosecond of `hold_n` falling. A wrong address counter surfaces only at a byte boundary or at the top-to-zero wrap, so the bench reads back bursts that cross both.

// File: rtl/ssram_pkg.sv
package ssram_pkg;

    localparam logic [7:0] CMD_RD_ARRAY = 8'h03;
    localparam logic [7:0] CMD_WR_ARRAY = 8'h02;
    localparam logic [7:0] CMD_RD_STAT  = 8'h05;
    localparam logic [7:0] CMD_WR_STAT  = 8'h01;

    localparam int ADDR_FIELD_BITS = 16;
    localparam int BYTE_BITS       = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_WR_DATA,
        ST_RD_DATA,
        ST_WR_STAT,
        ST_RD_STAT,
        ST_DISCARD
    } seq_state_e;

endpackage

// File: rtl/ssram_sync.sv
module ssram_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= din;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/ssram_pause.sv
module ssram_pause (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic hold_s,
    input  logic sck_s,
    output logic paused,
    output logic rise_ok,
    output logic fall_ok
);

    logic sck_q;
    logic paused_q;
    logic paused_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_s;
    end

    always_comb begin
        if (!active)       paused_d = 1'b0;
        else if (paused_q) paused_d = !(hold_s && !sck_s);
        else               paused_d = !hold_s && !sck_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) paused_q <= 1'b0;
        else        paused_q <= paused_d;
    end

    assign paused  = paused_q;
    assign rise_ok = active && !paused_q && hold_s && sck_s && !sck_q;
    assign fall_ok = active && !paused_q && !sck_s && sck_q;

    // R9: with sck high a pause request is deferred
    a_r9_defer_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!paused_q && sck_s) |=> !paused_q);

    // R10: leaving the pause needs sck low
    a_r10_resume_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        (paused_q && sck_s && active) |=> paused_q);

    // R10: no edge is taken during a pause
    a_r10_no_edges_paused: assert property (@(posedge clk) disable iff (!rst_n)
        paused_q |-> (!rise_ok && !fall_ok));

endmodule

// File: rtl/ssram_mem.sv
module ssram_mem #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/ssram_seq.sv
module ssram_seq
    import ssram_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_active,
    input  logic          rise_ok,
    input  logic          fall_ok,
    input  logic          si_s,
    input  logic [7:0]    mem_rdata,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          so_bit,
    output logic          drive
);

    localparam int CW = $clog2(ADDR_FIELD_BITS);
    localparam logic [CW-1:0] LAST_BYTE_BIT = CW'(BYTE_BITS - 1);
    localparam logic [CW-1:0] LAST_ADDR_BIT = CW'(ADDR_FIELD_BITS - 1);
    localparam logic [AW-1:0] ADDR_TOP      = '1;

    seq_state_e state, state_nx;
    logic [CW-1:0]  cnt;
    logic [15:0]    shin;
    logic [15:0]    shin_nx;
    logic [AW-1:0]  addr;
    logic [7:0]     rd_sh;
    logic [7:0]     status;
    logic           so_q;
    logic           drive_q;
    logic           want_read;
    logic [7:0]     rd_src;

    assign shin_nx = {shin[14:0], si_s};
    assign rd_src  = (state == ST_RD_STAT) ? status : mem_rdata;

    // next-state decision
    always_comb begin
        state_nx = state;
        if (!cs_active) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:    state_nx = ST_OPCODE;
                ST_OPCODE: begin
                    if (rise_ok && cnt == LAST_BYTE_BIT) begin
                        unique case (shin_nx[7:0])
                            CMD_RD_ARRAY, CMD_WR_ARRAY: state_nx = ST_ADDR;
                            CMD_RD_STAT:                state_nx = ST_RD_STAT;
                            CMD_WR_STAT:                state_nx = ST_WR_STAT;
                            default:                    state_nx = ST_DISCARD;
                        endcase
                    end
                end
                ST_ADDR: begin
                    if (rise_ok && cnt == LAST_ADDR_BIT)
                        state_nx = want_read ? ST_RD_DATA : ST_WR_DATA;
                end
                ST_WR_STAT: begin
                    if (rise_ok && cnt == LAST_BYTE_BIT) state_nx = ST_DISCARD;
                end
                ST_WR_DATA, ST_RD_DATA, ST_RD_STAT, ST_DISCARD: state_nx = state;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            shin      <= '0;
            addr      <= '0;
            rd_sh     <= '0;
            status    <= '0;
            so_q      <= 1'b0;
            drive_q   <= 1'b0;
            want_read <= 1'b0;
        end else if (!cs_active) begin
            cnt     <= '0;
            drive_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: cnt <= '0;
                ST_OPCODE: begin
                    if (rise_ok) begin
                        shin <= shin_nx;
                        if (cnt == LAST_BYTE_BIT) begin
                            cnt       <= '0;
                            want_read <= (shin_nx[7:0] == CMD_RD_ARRAY);
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_ADDR: begin
                    if (rise_ok) begin
                        shin <= shin_nx;
                        if (cnt == LAST_ADDR_BIT) begin
                            cnt  <= '0;
                            addr <= shin_nx[AW-1:0];
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_WR_DATA: begin
                    if (rise_ok) begin
                        shin <= shin_nx;
                        if (cnt == LAST_BYTE_BIT) begin
                            cnt  <= '0;
                            addr <= addr + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_WR_STAT: begin
                    if (rise_ok) begin
                        shin <= shin_nx;
                        if (cnt == LAST_BYTE_BIT) begin
                            cnt    <= '0;
                            status <= shin_nx[7:0];
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_RD_DATA, ST_RD_STAT: begin
                    if (fall_ok) begin
                        drive_q <= 1'b1;
                        if (cnt == '0) {so_q, rd_sh} <= {rd_src, 1'b0};
                        else           {so_q, rd_sh} <= {rd_sh, 1'b0};
                        if (cnt == LAST_BYTE_BIT) begin
                            cnt <= '0;
                            if (state == ST_RD_DATA) addr <= addr + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_DISCARD: cnt <= cnt;
                default:    cnt <= '0;
            endcase
        end
    end

    assign mem_we    = cs_active && rise_ok && (state == ST_WR_DATA) && (cnt == LAST_BYTE_BIT);
    assign mem_addr  = addr;
    assign mem_wdata = shin_nx[7:0];
    assign so_bit    = so_q;
    assign drive     = drive_q;

    // R5: the address after the top byte is zero
    a_r5_addr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_addr == ADDR_TOP) |=> (addr == '0));

    // R11: an unknown command never turns the driver on
    a_r11_discard_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DISCARD) |-> !drive_q);

    // R3: deselect clears the sequence
    a_r3_deselect_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |=> (state == ST_IDLE && !drive_q));

    // R10: with no accepted edge the bit position is frozen
    a_r10_position_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_active && state != ST_IDLE && !rise_ok && !fall_ok) |=> $stable(cnt));

endmodule

// File: rtl/serial_sram_slave.sv
module serial_sram_slave #(
    parameter int ARRAY_AW    = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    output logic so,
    output logic so_oe
);

    logic cs_s, hold_s, sck_s, si_s;
    logic cs_active;
    logic paused, rise_ok, fall_ok;
    logic mem_we, drive, so_bit;
    logic [ARRAY_AW-1:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;

    ssram_sync #(
        .W       (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({cs_n, hold_n, sck, si}),
        .dout  ({cs_s, hold_s, sck_s, si_s})
    );

    assign cs_active = !cs_s;

    ssram_pause u_pause (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (cs_active),
        .hold_s  (hold_s),
        .sck_s   (sck_s),
        .paused  (paused),
        .rise_ok (rise_ok),
        .fall_ok (fall_ok)
    );

    ssram_seq #(.AW(ARRAY_AW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_active (cs_active),
        .rise_ok   (rise_ok),
        .fall_ok   (fall_ok),
        .si_s      (si_s),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .so_bit    (so_bit),
        .drive     (drive)
    );

    ssram_mem #(.AW(ARRAY_AW), .DW(8)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_addr),
        .wdata (mem_wdata),
        .raddr (mem_addr),
        .rdata (mem_rdata)
    );

    // raw hold_n gates the driver so release is immediate
    assign so    = so_bit;
    assign so_oe = drive && cs_active && !paused && hold_n;

    // R10: serial output holds still through a pause
    a_r10_output_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && $past(paused)) |-> $stable(so));

    // R8: a raw low pause pin never coincides with drive
    a_r8_hold_releases: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_n |-> !so_oe);

endmodule

// File: tb/serial_sram_slave_test.sv
`timescale 1ns/1ps
module serial_sram_slave_test;

    localparam int AW   = 11;
    localparam int HALF = 6;
    localparam logic [15:0] TOP = 16'((1 << AW) - 1);

    localparam int NV = 6;
    localparam logic [23:0] VEC [NV] = '{
        {16'h0000, 8'hA5}, {16'h0001, 8'h3C}, {16'h0123, 8'hFF},
        {16'h07FE, 8'h00}, {16'h0400, 8'h81}, {16'h02AA, 8'h55}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
    logic so, so_oe;

    int n_chk = 0, n_fail = 0, oe_cycles = 0;

    always #4 clk = ~clk;

    always @(posedge clk) if (so_oe) oe_cycles <= oe_cycles + 1;

    serial_sram_slave #(.ARRAY_AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
        .si(si), .hold_n(hold_n), .so(so), .so_oe(so_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_xfer(input logic b, output logic r);
        si = b;
        tick(HALF);
        r = so;
        sck = 1'b1;
        tick(HALF);
        sck = 1'b0;
    endtask

    task automatic byte_xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            logic r;
            bit_xfer(tx[i], r);
            rx[i] = r;
        end
    endtask

    task automatic sel();
        cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic desel();
        tick(HALF);
        cs_n = 1'b1;
        tick(2 * HALF);
    endtask

    task automatic head(input logic [7:0] cmd, input logic [15:0] a);
        logic [7:0] d;
        byte_xfer(cmd, d);
        byte_xfer(a[15:8], d);
        byte_xfer(a[7:0], d);
    endtask

    task automatic wr_byte(input logic [15:0] a, input logic [7:0] v);
        logic [7:0] d;
        sel();
        head(8'h02, a);
        byte_xfer(v, d);
        desel();
    endtask

    task automatic rd_byte(input logic [15:0] a, output logic [7:0] v);
        sel();
        head(8'h03, a);
        byte_xfer(8'h00, v);
        desel();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] d, e;
        logic b;
        int oe0;

        tick(5);
        check("R3 reset so_oe", 32'(so_oe), 0);
        rst_n = 1'b1;
        tick(5);
        check("R3 idle so_oe", 32'(so_oe), 0);

        // R7 reset status, R1 status read code
        sel();
        byte_xfer(8'h05, d);
        byte_xfer(8'h00, d);
        desel();
        check("R7 status after reset", 32'(d), 32'h00);

        // R1 R2 table of single writes then read-backs
        for (int k = 0; k < NV; k++) wr_byte(VEC[k][23:8], VEC[k][7:0]);
        for (int k = 0; k < NV; k++) begin
            rd_byte(VEC[k][23:8], d);
            check("R1 R2 table read-back", 32'(d), 32'(VEC[k][7:0]));
        end

        // R5 burst write and read
        sel();
        head(8'h02, 16'h0200);
        byte_xfer(8'h10, d); byte_xfer(8'h20, d); byte_xfer(8'h30, d);
        desel();
        sel();
        head(8'h03, 16'h0200);
        for (int k = 1; k <= 3; k++) begin
            byte_xfer(8'h00, d);
            check("R5 burst read", 32'(d), 32'(k * 16));
        end
        desel();

        // R5 wrap from top to zero
        sel();
        head(8'h02, TOP);
        byte_xfer(8'h11, d); byte_xfer(8'h22, d);
        desel();
        rd_byte(TOP, d);
        check("R5 top byte", 32'(d), 32'h11);
        rd_byte(16'h0000, d);
        check("R5 wrapped byte", 32'(d), 32'h22);
        sel();
        head(8'h03, TOP);
        byte_xfer(8'h00, d); byte_xfer(8'h00, e);
        desel();
        check("R5 read wrap", 32'({d, e}), 32'h1122);

        // R4 upper address bits ignored
        wr_byte(16'hF805, 8'h77);
        rd_byte(16'h0005, d);
        check("R4 upper bits ignored", 32'(d), 32'h77);

        // R6 partial byte discarded
        wr_byte(16'h0010, 8'h5A);
        sel();
        head(8'h02, 16'h0010);
        for (int i = 0; i < 4; i++) bit_xfer(1'b1, b);
        desel();
        rd_byte(16'h0010, d);
        check("R6 partial byte dropped", 32'(d), 32'h5A);

        // R7 status write, extra byte ignored, repeated read
        sel();
        byte_xfer(8'h01, d); byte_xfer(8'h8C, d); byte_xfer(8'hFF, d);
        desel();
        sel();
        byte_xfer(8'h05, d);
        byte_xfer(8'h00, d); byte_xfer(8'h00, e);
        desel();
        check("R7 status first", 32'(d), 32'h8C);
        check("R7 status repeat", 32'(e), 32'h8C);

        // R11 unknown command keeps output off
        oe0 = oe_cycles;
        sel();
        byte_xfer(8'hFF, d); byte_xfer(8'h00, d); byte_xfer(8'h00, d);
        desel();
        check("R11 no drive after bad code", 32'(oe_cycles - oe0), 0);
        rd_byte(16'h0001, d);
        check("R11 array untouched", 32'(d), 32'h3C);

        // R3 raise select mid read
        sel();
        head(8'h03, 16'h0000);
        for (int i = 0; i < 3; i++) bit_xfer(1'b0, b);
        check("R3 drive during read", 32'(so_oe), 1);
        cs_n = 1'b1;
        tick(5);
        check("R3 drive off after deselect", 32'(so_oe), 0);
        tick(2 * HALF);

        // R8 R10 pause with sck low during a read
        wr_byte(16'h0030, 8'hC6);
        sel();
        head(8'h03, 16'h0030);
        for (int i = 7; i >= 4; i--) begin bit_xfer(1'b0, b); d[i] = b; end
        hold_n = 1'b0;
        #1;
        check("R8 immediate release sck low", 32'(so_oe), 0);
        tick(HALF);
        sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF);
        sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF);
        hold_n = 1'b1;
        tick(HALF);
        for (int i = 3; i >= 0; i--) begin bit_xfer(1'b0, b); d[i] = b; end
        desel();
        check("R10 read resumes exact bit", 32'(d), 32'hC6);

        // R9 R10 pause with sck high during a write of 0x93
        sel();
        head(8'h02, 16'h0040);
        bit_xfer(1'b1, b); bit_xfer(1'b0, b); bit_xfer(1'b0, b);
        si = 1'b1;
        tick(HALF);
        sck = 1'b1;
        tick(HALF);
        hold_n = 1'b0;
        tick(3);
        sck = 1'b0;
        tick(HALF);
        si = 1'b1;
        sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF);
        hold_n = 1'b1;
        tick(HALF);
        bit_xfer(1'b0, b); bit_xfer(1'b0, b); bit_xfer(1'b1, b); bit_xfer(1'b1, b);
        desel();
        rd_byte(16'h0040, d);
        check("R9 R10 write across deferred pause", 32'(d), 32'h93);

        // R8 R9 pause with sck high during a status read
        sel();
        byte_xfer(8'h05, d);
        for (int i = 7; i >= 5; i--) begin bit_xfer(1'b0, b); d[i] = b; end
        si = 1'b0;
        tick(HALF);
        b = so;
        d[4] = b;
        sck = 1'b1;
        tick(HALF);
        hold_n = 1'b0;
        #1;
        check("R8 immediate release sck high", 32'(so_oe), 0);
        tick(3);
        sck = 1'b0;
        tick(HALF);
        hold_n = 1'b1;
        tick(HALF);
        for (int i = 3; i >= 0; i--) begin bit_xfer(1'b0, b); d[i] = b; end
        desel();
        check("R9 status across deferred pause", 32'(d), 32'h8C);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule